// File: doc/BRIEF.md
# Paired-Channel Conversion Trigger Controller

This block is the digital control core of a six-channel converter whose channels are sampled in pairs (channels 0-1, 2-3 and 4-5). It accepts three active-high start strobes, one per pair, and synchronises them into the system clock. When it accepts a start, it runs a single conversion window of fixed length and raises a busy flag for that window. Start edges that arrive while busy is high are ignored, so starts from several pairs merge into one window. At the end of the window it publishes a mask of the pairs that converted and one result word per channel. The analog part is a stub that returns a fixed code per channel, with the top bit carrying the range in use. Channels that did not convert read as zero.

A mode input selects between two ways of choosing pairs and input ranges. In hardware mode each strobe starts its own pair, and a range pin is sampled when busy falls. In software mode the first strobe alone starts a conversion. The pairs and their per-pair ranges then come from a small control register. In hardware mode a pair that converted and whose strobe is already low when busy falls goes into power-down. The next rising edge on its strobe wakes it, and the pair takes no new start until a fixed power-up count has run out.

Top module: `conv_trig_ctrl`

## Requirements
- R1: After reset, busy_o is 0, done_mask_o is 0, range_o is 0 (wide range on all pairs), pair_down_o is 0 and every result word is 0.
- R2: In hardware mode, a rising edge on strobe_i[p] of a pair that is not down starts a conversion of pair p. Busy_o is high after the third rising clock edge that samples the strobe high (two synchroniser stages, then the edge detector). Edges of several pairs that are seen in the same cycle join one conversion.
- R3: Busy_o stays high for exactly CONV_CYCLES clock cycles per conversion.
- R4: A rising strobe edge of any pair while busy_o is high neither lengthens the window nor changes the converted mask. It also does not start a conversion later.
- R5: done_mask_o is loaded when busy falls, with bit p set when pair p converted in that window. Result word k sits at result_o[k*DATA_W +: DATA_W] and belongs to pair k/2. If pair k/2 converted, its value is {range bit of pair k/2 at the start, ((k+1)*37) mod 2^(DATA_W-1)}. Otherwise it is 0.
- R6: In software mode only strobe_i[0] starts a conversion. The converted pairs are the set bits of the control register's pair field (cfg_data_i bit 3+p selects pair p). An empty field, or a strobe on pair 1 or 2 alone, starts nothing.
- R7: The control register holds six bits and resets to all zeros. It loads cfg_data_i on a clock edge where cfg_we_i is high.
- R8: In hardware mode, range_o takes the value {3{range_pin_i}} when busy falls; 1 means narrow and 0 means wide. Until the first fall after reset, range_o stays wide.
- R9: In software mode, range_o[p] equals control register bit p (cfg_data_i bits 2:0), from the cycle after the write.
- R10: Each conversion uses the range_o value present in the cycle it starts.
- R11: In hardware mode, when busy falls, a pair that converted in that window and whose synchronised strobe is low sets its pair_down_o bit. In software mode no pair powers down.
- R12: A rising strobe edge on a down pair starts power-up and does not convert. pair_down_o stays high for PWRUP_CYCLES more cycles, and start edges during that time are ignored. After that the pair starts conversions again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strobe_i | input | 3 | Asynchronous start strobes, bit p for pair p |
| sw_mode_i | input | 1 | 1 = software mode, 0 = hardware mode |
| range_pin_i | input | 1 | Range pin for hardware mode, 1 = narrow |
| cfg_we_i | input | 1 | Control register write enable |
| cfg_data_i | input | 6 | Control word: bits 5:3 pair select, bits 2:0 per-pair range |
| busy_o | output | 1 | High during a conversion |
| done_mask_o | output | 3 | Pairs converted in the last window |
| range_o | output | 3 | Range for the next conversion per pair, 1 = narrow |
| pair_down_o | output | 3 | Pair powered down or powering up |
| result_o | output | 6*DATA_W | Six result words, channel 0 lowest |

## Verification
The bench builds the block with CONV_CYCLES=8, PWRUP_CYCLES=12 and DATA_W=16. These values keep each conversion window and each wake-up short. A full sweep therefore fits easily: all seven hardware pair masks with alternating range pin values, and all seven software masks with a different range pattern each. With these short windows the bench can also place a strobe edge inside a busy window, or inside the power-up count, and count the exact cycles. Expected result words come from the per-channel arithmetic in R5.

// File: rtl/conv_pkg.sv
// Shared constants for the paired-channel conversion controller.
// Assumes six channels organised as three pairs.
package conv_pkg;
    localparam int NPAIR     = 3;
    localparam int NCH       = 2 * NPAIR;
    localparam int STUB_STEP = 37;
endpackage

// File: rtl/strobe_sync.sv
// Two-stage synchroniser with rising-edge detect for one start strobe.
// Assumes the strobe is held for at least two clock cycles.
module strobe_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic rise_o
);
    logic s1_q, s2_q, s3_q;

    // Shift the strobe through the synchroniser and the edge history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= async_i;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign level_o = s2_q;
    assign rise_o  = s2_q & ~s3_q;
endmodule

// File: rtl/conv_timer.sv
// Fixed-length conversion window. It stands for the converter's internal clock.
// Assumes start_i is only acted on while idle.
module conv_timer #(
    parameter int CONV_CYCLES = 375
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    localparam int CW = $clog2(CONV_CYCLES + 1);

    logic          busy_q;
    logic [CW-1:0] cnt_q;

    // Load the counter on a start, then count down to the end of the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!busy_q && start_i) begin
            busy_q <= 1'b1;
            cnt_q  <= CW'(CONV_CYCLES - 1);
        end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign busy_o = busy_q;
    assign done_o = busy_q && (cnt_q == '0);

    a_r3_window_holds: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && (cnt_q != '0) |=> busy_q);
    a_r3_window_ends: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_q);
    a_r4_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && $past(busy_q) |-> cnt_q < $past(cnt_q));
endmodule

// File: rtl/pair_ctrl.sv
// Power state for one channel pair: active, powered down, or powering up.
// Assumes the sleep request comes only at the end of a conversion window.
module pair_ctrl #(
    parameter int PWRUP_CYCLES = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_i,
    input  logic wake_i,
    output logic down_o
);
    localparam int PW = $clog2(PWRUP_CYCLES + 1);

    logic          pd_q;
    logic          pu_q;
    logic [PW-1:0] pu_cnt_q;

    // Step the pair through power-down and the timed power-up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pd_q     <= 1'b0;
            pu_q     <= 1'b0;
            pu_cnt_q <= '0;
        end else if (pd_q) begin
            if (wake_i) begin
                pd_q     <= 1'b0;
                pu_q     <= 1'b1;
                pu_cnt_q <= PW'(PWRUP_CYCLES - 1);
            end
        end else if (pu_q) begin
            if (pu_cnt_q == '0) pu_q     <= 1'b0;
            else                pu_cnt_q <= pu_cnt_q - 1'b1;
        end else if (sleep_i) begin
            pd_q <= 1'b1;
        end
    end

    assign down_o = pd_q | pu_q;

    a_r11_sleep_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_q) |-> $past(sleep_i));
    a_r12_wake_to_pwrup: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pd_q) |-> pu_q);
    a_r12_wake_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pd_q) |-> $past(wake_i));
endmodule

// File: rtl/adc_stub.sv
// Stand-in for one channel's analog converter: a fixed code per channel.
// The top bit reports the range the conversion used.
module adc_stub #(
    parameter int CH     = 0,
    parameter int DATA_W = 16
) (
    input  logic              narrow_i,
    output logic [DATA_W-1:0] code_o
);
    localparam int BASE = ((CH + 1) * conv_pkg::STUB_STEP) % (1 << (DATA_W - 1));

    assign code_o = {narrow_i, (DATA_W-1)'(BASE)};
endmodule

// File: rtl/conv_trig_ctrl.sv
// Trigger controller for six channels sampled in pairs. It merges the pair strobes into
// one busy window, selects pairs and ranges by mode, and tracks pair power-down.
// Assumes a synchronous active-low reset and strobes that are slow next to clk.
module conv_trig_ctrl #(
    parameter int CONV_CYCLES  = 375,
    parameter int PWRUP_CYCLES = 250,
    parameter int DATA_W       = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [2:0]                    strobe_i,
    input  logic                          sw_mode_i,
    input  logic                          range_pin_i,
    input  logic                          cfg_we_i,
    input  logic [5:0]                    cfg_data_i,
    output logic                          busy_o,
    output logic [2:0]                    done_mask_o,
    output logic [2:0]                    range_o,
    output logic [2:0]                    pair_down_o,
    output logic [conv_pkg::NCH*DATA_W-1:0] result_o
);
    import conv_pkg::*;

    logic [NPAIR-1:0] lvl, rise, down, sleep_req;
    logic [NPAIR-1:0] hw_req, sw_req, new_mask;
    logic [NPAIR-1:0] cur_mask_q, conv_rng_q, range_hw_q, done_mask_q;
    logic [5:0]       ctrl_q;
    logic             busy, done, start_go;

    // Per-pair synchroniser and power state.
    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        strobe_sync u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (strobe_i[p]),
            .level_o (lvl[p]),
            .rise_o  (rise[p])
        );
        assign sleep_req[p] = done && !sw_mode_i && cur_mask_q[p] && !lvl[p];
        pair_ctrl #(.PWRUP_CYCLES(PWRUP_CYCLES)) u_pwr (
            .clk     (clk),
            .rst_n   (rst_n),
            .sleep_i (sleep_req[p]),
            .wake_i  (rise[p]),
            .down_o  (down[p])
        );
    end

    // Control register write.
    always_ff @(posedge clk) begin
        if (!rst_n)        ctrl_q <= '0;
        else if (cfg_we_i) ctrl_q <= cfg_data_i;
    end

    // Pair selection for a new conversion.
    always_comb begin
        hw_req   = rise & ~down;
        sw_req   = (rise[0] && !down[0]) ? (ctrl_q[5:3] & ~down) : '0;
        new_mask = sw_mode_i ? sw_req : hw_req;
        start_go = !busy && (new_mask != '0);
    end

    conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_go),
        .busy_o  (busy),
        .done_o  (done)
    );

    // Capture the converting pairs and their ranges at the start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_mask_q <= '0;
            conv_rng_q <= '0;
        end else if (start_go) begin
            cur_mask_q <= new_mask;
            conv_rng_q <= range_o;
        end
    end

    // Sample the range pin and publish the mask when busy falls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            range_hw_q  <= '0;
            done_mask_q <= '0;
        end else if (done) begin
            done_mask_q <= cur_mask_q;
            if (!sw_mode_i) range_hw_q <= {NPAIR{range_pin_i}};
        end
    end

    // Result words from the stub, loaded when busy falls.
    for (genvar k = 0; k < NCH; k++) begin : g_ch
        logic [DATA_W-1:0] code, res_q;
        adc_stub #(.CH(k), .DATA_W(DATA_W)) u_stub (
            .narrow_i (conv_rng_q[k/2]),
            .code_o   (code)
        );
        // Keep the code of a converted channel, zero otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n)    res_q <= '0;
            else if (done) res_q <= cur_mask_q[k/2] ? code : '0;
        end
        assign result_o[k*DATA_W +: DATA_W] = res_q;
    end

    assign range_o     = sw_mode_i ? ctrl_q[2:0] : range_hw_q;
    assign busy_o      = busy;
    assign done_mask_o = done_mask_q;
    assign pair_down_o = down;

    a_r4_mask_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(cur_mask_q));
    a_r12_no_down_pair: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (cur_mask_q & $past(down)) == '0);
    a_r6_sw_pairs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) && $past(sw_mode_i) |-> (cur_mask_q & ~$past(ctrl_q[5:3])) == '0);
    a_r8_range_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(range_hw_q));
endmodule

// File: tb/test_conv_trig_ctrl.sv
module test_conv_trig_ctrl;
    localparam int C  = 8;
    localparam int PU = 12;
    localparam int W  = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   strobe = '0;
    logic         sw_mode = 1'b0;
    logic         range_pin = 1'b0;
    logic         cfg_we = 1'b0;
    logic [5:0]   cfg_data = '0;
    logic         busy;
    logic [2:0]   done_mask, range_v, pair_down;
    logic [6*W-1:0] result;

    int  total = 0;
    int  bad = 0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;

    conv_trig_ctrl #(.CONV_CYCLES(C), .PWRUP_CYCLES(PU), .DATA_W(W)) i_conv_trig_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe_i    (strobe),
        .sw_mode_i   (sw_mode),
        .range_pin_i (range_pin),
        .cfg_we_i    (cfg_we),
        .cfg_data_i  (cfg_data),
        .busy_o      (busy),
        .done_mask_o (done_mask),
        .range_o     (range_v),
        .pair_down_o (pair_down),
        .result_o    (result)
    );

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [6*W-1:0] exp_res(input logic [2:0] mask, input logic [2:0] rng);
        logic [6*W-1:0] r = '0;
        for (int k = 0; k < 6; k++)
            if (mask[k/2]) r[k*W +: W] = {rng[k/2], 15'(((k + 1) * 37) % 32768)};
        return r;
    endfunction

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Raise the strobes, measure latency and window length; optionally drop them during busy.
    task automatic conv(input logic [2:0] bits, input bit hold, output int lat, output int len);
        @(negedge clk);
        strobe = strobe | bits;
        lat = 0;
        while (!busy && lat < 20) begin @(negedge clk); lat++; end
        if (!hold) strobe = strobe & ~bits;
        len = 0;
        while (busy && len < 100) begin @(negedge clk); len++; end
    endtask

    task automatic release_strobes();
        strobe = '0;
        wait_n(4);
    endtask

    task automatic quiet(input int n, input string tag);
        bit seen = 1'b0;
        for (int i = 0; i < n; i++) begin @(negedge clk); if (busy) seen = 1'b1; end
        check(!seen, tag, seen, 0);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int lat, len;
        logic [2:0] exp_rng;
        logic [5:0] cw;

        wait_n(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(busy == 0, "R1 busy", busy, 0);
        check(done_mask == 0, "R1 mask", done_mask, 0);
        check(range_v == 0, "R1 range", range_v, 0);
        check(pair_down == 0, "R1 down", pair_down, 0);
        check(result == 0, "R1 result", result, 0);

        // R2 R3 R5 R8 R10: hardware sweep of every pair mask
        exp_rng = 3'b000;
        for (int m = 1; m < 8; m++) begin
            range_pin = ~m[0];
            conv(3'(m), 1'b1, lat, len);
            check(lat == 3, "R2 latency", lat, 3);
            check(len == C, "R3 window", len, C);
            check(done_mask == 3'(m), "R5 mask", done_mask, m);
            check(result == exp_res(3'(m), exp_rng), "R5 R10 result", result, exp_res(3'(m), exp_rng));
            exp_rng = {3{range_pin}};
            check(range_v == exp_rng, "R8 range", range_v, exp_rng);
            check(pair_down == 0, "R11 held strobe keeps pair up", pair_down, 0);
            release_strobes();
        end

        // R4: an edge during busy is ignored
        @(negedge clk);
        strobe = 3'b001;
        while (!busy) @(negedge clk);
        wait_n(2);
        strobe = 3'b011;
        len = 2;
        while (busy && len < 100) begin @(negedge clk); len++; end
        check(len == C, "R4 window not extended", len, C);
        check(done_mask == 3'b001, "R4 mask unchanged", done_mask, 3'b001);
        exp_rng = {3{range_pin}};
        quiet(12, "R4 no late start");
        release_strobes();

        // R11: short strobe powers the pair down
        conv(3'b010, 1'b0, lat, len);
        exp_rng = {3{range_pin}};
        check(done_mask == 3'b010, "R11 mask", done_mask, 3'b010);
        check(pair_down == 3'b010, "R11 down", pair_down, 3'b010);
        wait_n(4);
        check(pair_down == 3'b010, "R11 stays down", pair_down, 3'b010);

        // R12: wake edge does not convert; edges during power-up are ignored
        strobe = 3'b010;
        quiet(3, "R12 wake no convert");
        check(pair_down == 3'b010, "R12 powering up", pair_down, 3'b010);
        strobe = 3'b000;
        wait_n(2);
        strobe = 3'b010;
        quiet(5, "R12 edge in power-up ignored");
        strobe = 3'b000;
        wait_n(PU + 4);
        check(pair_down == 3'b000, "R12 up again", pair_down, 3'b000);
        conv(3'b010, 1'b1, lat, len);
        check(lat == 3 && done_mask == 3'b010, "R12 converts after power-up", {lat, done_mask}, {32'd3, 3'b010});
        release_strobes();

        // R6 R7 R9: software mode
        sw_mode = 1'b1;
        @(negedge clk);
        check(range_v == 3'b000, "R7 register reset", range_v, 0);
        strobe = 3'b001;
        quiet(6, "R6 empty pair field");
        release_strobes();
        for (int m = 1; m < 8; m++) begin
            cw = {3'(m), ~3'(m)};
            cfg_data = cw;
            cfg_we = 1'b1;
            @(negedge clk);
            cfg_we = 1'b0;
            check(range_v == cw[2:0], "R9 sw range", range_v, cw[2:0]);
            strobe = 3'b110;
            quiet(6, "R6 other strobes ignored");
            release_strobes();
            conv(3'b001, 1'b0, lat, len);
            check(lat == 3 && len == C, "R6 R3 sw timing", {lat, len}, {32'd3, 32'(C)});
            check(done_mask == 3'(m), "R6 sw mask", done_mask, m);
            check(result == exp_res(3'(m), cw[2:0]), "R6 R10 sw result", result, exp_res(3'(m), cw[2:0]));
            check(pair_down == 0, "R11 no sw power-down", pair_down, 0);
            release_strobes();
        end

        // R8: hardware range register untouched by software-mode falls
        sw_mode = 1'b0;
        @(negedge clk);
        check(range_v == exp_rng, "R8 hw range kept", range_v, exp_rng);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule